// File: doc/BRIEF.md
# Bipolar Level and Slope Trip Detector

This block watches one channel of signed 24-bit voltage samples that arrive at a low rate, a few tens of hertz, each marked by a valid strobe. It raises a latched trip when a sample fails either of two checks, in either polarity. The level check compares the sample's magnitude against a programmable level limit. The slope check compares the change since the previous sample against a programmable slope limit.

The slope check is armed and disarmed by command strobes. Right after arming, the slope check uses a raised limit, four times the programmed one, for a fixed number of compared samples. It then drops back to the programmed limit. Both limits are entered as codes in 10 mV steps and converted to LSB units once, when they are loaded, so each sample costs one magnitude compare. An extended-range setting multiplies both limits by four.

Samples enter through a valid/ready port that never applies back-pressure once reset is released. A sample is taken in every cycle in which `s_valid` and `s_ready` are both high. The upstream side may hold `s_valid` low for any number of cycles. Samples that arrive while `s_ready` is low, which happens only during reset, are not taken.

Top module: `vtrip_detector`

## Requirements
- R1: `s_ready` is high in every cycle after reset is released, and each cycle with `s_valid` high takes exactly one sample.
- R2: A level code c gives a limit of c*32768 LSB (10 mV with 2^23 LSB = 2.56 V), times 4 when extended range is set. A sample whose magnitude is strictly greater than the limit trips. This applies to positive and negative samples, including the most negative code.
- R3: While armed, a sample trips when |sample - previous sample| is strictly greater than the slope limit. The slope limit is the slope code times 32768 LSB, times 4 in extended range. A rise or a fall both trip.
- R4: For the first HOLD_SAMPLES slope comparisons after an arm strobe, the slope limit is four times its normal value, and `rate_hold` is high. After that the normal limit applies and `rate_hold` is low.
- R5: The first sample taken after an arm strobe only becomes the previous sample and can never cause a slope trip.
- R6: A trip stays latched, together with its cause and polarity, until it is cleared. Later violations do not change it. `trip_cause` is 0 for level and 1 for slope, and the level cause wins when both checks fail on one sample. `trip_neg` is 1 for a negative sample (level) or a negative change (slope).
- R7: A `trip_clear` strobe clears the trip, cause and polarity at the next edge. It takes priority over a violation taken in the same cycle.
- R8: A `rate_disarm` strobe clears `rate_armed` at the next edge, and no slope trip occurs while disarmed. A disarm wins over an arm strobe given in the same cycle.
- R9: A violating sample shows up on `trip` right after the clock edge that takes it.
- R10: Writes with `cfg_addr`=0 load the level code from `cfg_wdata[7:0]`. Writes with `cfg_addr`=1 load the slope code from `cfg_wdata[3:0]` and the extended-range flag from `cfg_wdata[7]`. A sample taken at the edge right after the write edge still sees the old limits, and the sample after that sees the new ones.
- R11: After reset `trip`, `trip_cause`, `trip_neg`, `rate_armed` and `rate_hold` are 0, the level code is 0xFF, the slope code is 0xF, and extended range is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready (high after reset) |
| s_data | input | 24 | Signed sample, LSB = 2.56 V / 2^23 |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_addr | input | 1 | 0: level code, 1: slope code and range flag |
| cfg_wdata | input | 8 | Write data |
| rate_arm | input | 1 | Arm the slope check (restarts the raised-limit period) |
| rate_disarm | input | 1 | Disarm the slope check |
| trip_clear | input | 1 | Clear the latched trip |
| trip | output | 1 | Latched trip |
| trip_cause | output | 1 | 0 level, 1 slope |
| trip_neg | output | 1 | Polarity of the violation, 1 negative |
| rate_armed | output | 1 | Slope check armed |
| rate_hold | output | 1 | Raised slope limit in force |

## Verification
The bench builds the block with HOLD_SAMPLES set to 3 and keeps the other parameters at their defaults. This makes the whole raised-limit period take only a few samples, so the bench can show the switch to the normal limit right after the third comparison. The limit codes are chosen so that the level and slope boundaries, at the exact limit and one LSB above it, fall on simple sample values. The same sequence covers the seed sample, the cause priority, the sticky latch and the timing of a limit change.

// File: rtl/vtrip_pkg.sv
package vtrip_pkg;
  typedef enum logic {CAUSE_LEVEL = 1'b0, CAUSE_SLOPE = 1'b1} trip_cause_e;

  typedef struct packed {
    logic hit;
    logic neg;
  } chk_res_t;
endpackage

// File: rtl/vtrip_limit_regs.sv
module vtrip_limit_regs #(
  parameter int CFG_W       = 8,
  parameter int LVL_CODE_W  = 8,
  parameter int SLP_CODE_W  = 4,
  parameter int STEP_SHIFT  = 15,
  parameter int EXT_SHIFT   = 2,
  parameter int RAISE_SHIFT = 2,
  parameter int MAG_W       = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [MAG_W-1:0] lvl_limit,
  output logic [MAG_W-1:0] slp_limit,
  output logic [MAG_W-1:0] slp_limit_raised
);
  localparam logic [LVL_CODE_W-1:0] LVL_RST = '1;
  localparam logic [SLP_CODE_W-1:0] SLP_RST = '1;

  logic [LVL_CODE_W-1:0] lvl_code;
  logic [SLP_CODE_W-1:0] slp_code;
  logic                  ext_q;
  logic                  unused_cfg;

  assign unused_cfg = ^cfg_wdata;

  function automatic logic [MAG_W-1:0] scale(input logic [MAG_W-1:0] code,
                                             input logic ext, input int extra);
    logic [MAG_W-1:0] v;
    v = code << STEP_SHIFT;
    if (ext) v = v << EXT_SHIFT;
    return v << extra;
  endfunction

  // code registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_code <= LVL_RST;
      slp_code <= SLP_RST;
      ext_q    <= 1'b0;
    end else if (cfg_we) begin
      if (!cfg_addr) begin
        lvl_code <= cfg_wdata[LVL_CODE_W-1:0];
      end else begin
        slp_code <= cfg_wdata[SLP_CODE_W-1:0];
        ext_q    <= cfg_wdata[CFG_W-1];
      end
    end
  end

  // one-time conversion to LSB units
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_limit        <= scale(MAG_W'(LVL_RST), 1'b0, 0);
      slp_limit        <= scale(MAG_W'(SLP_RST), 1'b0, 0);
      slp_limit_raised <= scale(MAG_W'(SLP_RST), 1'b0, RAISE_SHIFT);
    end else begin
      lvl_limit        <= scale(MAG_W'(lvl_code), ext_q, 0);
      slp_limit        <= scale(MAG_W'(slp_code), ext_q, 0);
      slp_limit_raised <= scale(MAG_W'(slp_code), ext_q, RAISE_SHIFT);
    end
  end

  // R4: raised limit never below the normal one
  a_r4_raised_ge_normal: assert property (@(posedge clk) disable iff (!rst_n)
    slp_limit_raised >= slp_limit);
endmodule

// File: rtl/vtrip_mag_cmp.sv
module vtrip_mag_cmp #(
  parameter int IN_W  = 24,
  parameter int MAG_W = 29
) (
  input  logic [IN_W-1:0]     val,
  input  logic [MAG_W-1:0]    limit,
  output vtrip_pkg::chk_res_t res
);
  localparam int EXT_W = MAG_W - IN_W;

  logic [MAG_W-1:0] wide;
  logic [MAG_W-1:0] mag;

  always_comb begin
    wide    = {{EXT_W{val[IN_W-1]}}, val};
    mag     = val[IN_W-1] ? (~wide + 1'b1) : wide;
    res.hit = mag > limit;
    res.neg = val[IN_W-1];
  end
endmodule

// File: rtl/vtrip_slope_track.sv
module vtrip_slope_track #(
  parameter int DATA_W       = 24,
  parameter int HOLD_SAMPLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_fire,
  input  logic [DATA_W-1:0] sample,
  input  logic              arm,
  input  logic              disarm,
  output logic [DATA_W:0]   delta,
  output logic              cmp_en,
  output logic              use_raised,
  output logic              armed
);
  localparam int CNT_W = $clog2(HOLD_SAMPLES + 1);

  logic [DATA_W-1:0] prev;
  logic              seeded;
  logic [CNT_W-1:0]  hold_cnt;

  assign delta      = {sample[DATA_W-1], sample} - {prev[DATA_W-1], prev};
  assign cmp_en     = smp_fire && armed && seeded && !arm && !disarm;
  assign use_raised = armed && (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      seeded   <= 1'b0;
      prev     <= '0;
      hold_cnt <= '0;
    end else if (disarm) begin
      armed    <= 1'b0;
      seeded   <= 1'b0;
      hold_cnt <= '0;
    end else if (arm) begin
      armed    <= 1'b1;
      seeded   <= 1'b0;
      hold_cnt <= CNT_W'(HOLD_SAMPLES);
    end else if (smp_fire && armed) begin
      prev   <= sample;
      seeded <= 1'b1;
      if (seeded && hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
    end
  end

  // R8: disarm wins and takes effect at the next edge
  a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> !armed);
  // R4: hold counter bounded by its load value
  a_r4_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= CNT_W'(HOLD_SAMPLES));
  // R5: arming is always followed by an unseeded state
  a_r5_seed_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !disarm) |=> (armed && !seeded));
endmodule

// File: rtl/vtrip_trip_latch.sv
module vtrip_trip_latch (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                lvl_en,
  input  vtrip_pkg::chk_res_t lvl_res,
  input  logic                slp_en,
  input  vtrip_pkg::chk_res_t slp_res,
  output logic                trip,
  output vtrip_pkg::trip_cause_e cause,
  output logic                neg
);
  import vtrip_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip  <= 1'b0;
      cause <= CAUSE_LEVEL;
      neg   <= 1'b0;
    end else if (clear) begin
      trip  <= 1'b0;
      cause <= CAUSE_LEVEL;
      neg   <= 1'b0;
    end else if (!trip) begin
      if (lvl_en && lvl_res.hit) begin
        trip  <= 1'b1;
        cause <= CAUSE_LEVEL;
        neg   <= lvl_res.neg;
      end else if (slp_en && slp_res.hit) begin
        trip  <= 1'b1;
        cause <= CAUSE_SLOPE;
        neg   <= slp_res.neg;
      end
    end
  end

  // R6: latched trip holds its cause and polarity
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !clear) |=> (trip && $stable(cause) && $stable(neg)));
  // R7: clear takes effect at the next edge
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !trip);
  // R9: a level violation is visible one edge later
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_en && lvl_res.hit && !clear) |=> trip);
endmodule

// File: rtl/vtrip_detector.sv
module vtrip_detector #(
  parameter int DATA_W       = 24,
  parameter int CFG_W        = 8,
  parameter int LVL_CODE_W   = 8,
  parameter int SLP_CODE_W   = 4,
  parameter int STEP_SHIFT   = 15,
  parameter int EXT_SHIFT    = 2,
  parameter int RAISE_SHIFT  = 2,
  parameter int HOLD_SAMPLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              rate_arm,
  input  logic              rate_disarm,
  input  logic              trip_clear,
  output logic              trip,
  output logic              trip_cause,
  output logic              trip_neg,
  output logic              rate_armed,
  output logic              rate_hold
);
  import vtrip_pkg::*;

  localparam int MAG_W = DATA_W + 1 + EXT_SHIFT + RAISE_SHIFT;

  logic             ready_q;
  logic             smp_fire;
  logic [MAG_W-1:0] lvl_limit, slp_limit, slp_limit_raised, slp_sel;
  logic [DATA_W:0]  delta;
  logic             slp_en, use_raised;
  chk_res_t         lvl_res, slp_res;
  trip_cause_e      cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign s_ready  = ready_q;
  assign smp_fire = s_valid && ready_q;

  vtrip_limit_regs #(
    .CFG_W(CFG_W), .LVL_CODE_W(LVL_CODE_W), .SLP_CODE_W(SLP_CODE_W),
    .STEP_SHIFT(STEP_SHIFT), .EXT_SHIFT(EXT_SHIFT),
    .RAISE_SHIFT(RAISE_SHIFT), .MAG_W(MAG_W)
  ) u_limits (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lvl_limit(lvl_limit), .slp_limit(slp_limit),
    .slp_limit_raised(slp_limit_raised)
  );

  vtrip_slope_track #(.DATA_W(DATA_W), .HOLD_SAMPLES(HOLD_SAMPLES)) u_slope (
    .clk(clk), .rst_n(rst_n), .smp_fire(smp_fire), .sample(s_data),
    .arm(rate_arm), .disarm(rate_disarm), .delta(delta), .cmp_en(slp_en),
    .use_raised(use_raised), .armed(rate_armed)
  );

  assign slp_sel   = use_raised ? slp_limit_raised : slp_limit;
  assign rate_hold = use_raised;

  vtrip_mag_cmp #(.IN_W(DATA_W), .MAG_W(MAG_W)) u_lvl_cmp (
    .val(s_data), .limit(lvl_limit), .res(lvl_res)
  );

  vtrip_mag_cmp #(.IN_W(DATA_W + 1), .MAG_W(MAG_W)) u_slp_cmp (
    .val(delta), .limit(slp_sel), .res(slp_res)
  );

  vtrip_trip_latch u_latch (
    .clk(clk), .rst_n(rst_n), .clear(trip_clear), .lvl_en(smp_fire),
    .lvl_res(lvl_res), .slp_en(slp_en), .slp_res(slp_res),
    .trip(trip), .cause(cause), .neg(trip_neg)
  );

  assign trip_cause = cause;

  // R1: once ready, stays ready
  a_r1_ready: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> s_ready);
  // R8: no slope-caused trip appears while disarmed
  a_r8_no_slope_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_armed && !trip) |=> !(trip && trip_cause));
endmodule

// File: tb/vtrip_detector_tb.sv
module vtrip_detector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_data = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        rate_arm = 1'b0, rate_disarm = 1'b0, trip_clear = 1'b0;
  logic        trip, trip_cause, trip_neg, rate_armed, rate_hold;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vtrip_detector #(.HOLD_SAMPLES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rate_arm(rate_arm), .rate_disarm(rate_disarm),
    .trip_clear(trip_clear), .trip(trip), .trip_cause(trip_cause),
    .trip_neg(trip_neg), .rate_armed(rate_armed), .rate_hold(rate_hold)
  );

  // {clear first, sample, trip, cause, neg}; level code 10, slope code 2, hold 3
  localparam logic [27:0] VEC [15] = '{
    {1'b0,  24'sd0,       3'b000},  // R5 seed
    {1'b0,  24'sd200000,  3'b000},  // R4 raised limit
    {1'b0,  24'sd0,       3'b000},  // R4 raised limit, fall
    {1'b0,  24'sd250000,  3'b000},  // R4 last raised compare
    {1'b0,  24'sd300000,  3'b000},  // R3 below normal limit
    {1'b0,  24'sd200000,  3'b111},  // R3 fall trips
    {1'b1,  24'sd210000,  3'b000},  // R7 cleared
    {1'b0,  24'sd327680,  3'b110},  // R2 at level limit, R3 rise trips
    {1'b1,  24'sd327681,  3'b100},  // R2 one above
    {1'b1,  24'sd300000,  3'b000},
    {1'b1,  24'sd350000,  3'b100},  // R2 level positive
    {1'b1, -24'sd300000,  3'b111},  // R3 large fall
    {1'b1, -24'sd400000,  3'b101},  // R6 level wins
    {1'b0,  24'sd0,       3'b101},  // R6 sticky
    {1'b1,  24'sd65536,   3'b000}   // R3 exactly at slope limit
  };

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send(input logic [23:0] x);
    @(negedge clk); s_valid = 1'b1; s_data = x;
    @(negedge clk); s_valid = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); trip_clear = 1'b1;
    @(negedge clk); trip_clear = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk); rate_arm = 1'b1;
    @(negedge clk); rate_arm = 1'b0;
  endtask

  function automatic logic [2:0] tv();
    return {trip, trip_cause, trip_neg};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R11 reset trip", tv(), 3'b000);
    chk("R11 reset armed/hold", {1'b0, rate_armed, rate_hold}, 3'b000);
    chk("R1 ready", {2'b00, s_ready}, 3'b001);

    // default level code 0xFF -> 8355840 LSB
    send(24'sd8355840);
    chk("R11 default level limit", tv(), 3'b000);
    send(24'sd8355841);
    chk("R2 over default limit (R9)", tv(), 3'b100);
    clr();
    chk("R7 clear", tv(), 3'b000);
    send(24'h800000);
    chk("R2 most negative", tv(), 3'b101);
    clr();

    wr(1'b0, 8'd10);
    wr(1'b1, 8'h02);
    tick();
    arm();
    chk("R4 hold after arm", {1'b0, rate_armed, rate_hold}, 3'b011);

    for (int i = 0; i < 15; i++) begin
      if (VEC[i][27]) clr();
      send(VEC[i][26:3]);
      chk($sformatf("R3/R4/R6 vector %0d", i), tv(), VEC[i][2:0]);
    end
    chk("R4 hold over", {2'b00, rate_hold}, 3'b000);

    @(negedge clk); rate_disarm = 1'b1;
    @(negedge clk); rate_disarm = 1'b0;
    chk("R8 disarm", {2'b00, rate_armed}, 3'b000);
    send(24'sd0);
    send(24'sd300000);
    chk("R8 no slope trip disarmed", tv(), 3'b000);

    // R10 timing: sample right after write edge sees old limit
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 8'h82;
    @(negedge clk); cfg_we = 1'b0; s_valid = 1'b1; s_data = 24'sd1000000;
    @(negedge clk); s_valid = 1'b0;
    chk("R10 old limit still used", tv(), 3'b100);
    clr();
    send(24'sd1000000);
    chk("R10 new ext limit (R2 ext)", tv(), 3'b000);
    send(24'sd1310721);
    chk("R2 over ext limit", tv(), 3'b100);
    clr();

    @(negedge clk); rate_arm = 1'b1; rate_disarm = 1'b1;
    @(negedge clk); rate_arm = 1'b0; rate_disarm = 1'b0;
    chk("R8 disarm wins", {2'b00, rate_armed}, 3'b000);

    @(negedge clk); trip_clear = 1'b1; s_valid = 1'b1; s_data = 24'sd2000000;
    @(negedge clk); trip_clear = 1'b0; s_valid = 1'b0;
    chk("R7 clear wins", tv(), 3'b000);

    // slope in extended range: normal limit 262144
    arm();
    send(24'sd0);
    send(24'sd0);
    send(24'sd0);
    send(24'sd0);
    chk("R4 hold done ext", {2'b00, rate_hold}, 3'b000);
    send(24'sd200000);
    chk("R3 ext slope no trip", tv(), 3'b000);
    send(24'sd500000);
    chk("R3 ext slope trip", tv(), 3'b110);
    clr();

    arm();
    send(-24'sd1000000);
    chk("R5 seed no trip", tv(), 3'b000);
    send(-24'sd1000000);
    chk("R5 after seed steady", tv(), 3'b000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule